// File: doc/BRIEF.md
# HDLC Receive Deframer

This block turns a serial HDLC bit stream, taken from one B or D channel time slot, into octets for a receive FIFO. Each bit is offered on `bit_in` together with a one-cycle `bit_en` strobe. The block finds opening and closing flags, strips the zero inserted after every run of five ones, and builds octets least significant bit first. It runs the frame check sequence over the whole frame and can drop frames whose first octet is not a station address it accepts. Payload octets go out on a single-cycle FIFO write strobe. The two check-sequence octets are held back and never written. The final payload octet of each frame carries an end marker and a three-bit status.

Frames are delivered only after they reach a minimum length. The block holds the newest three octets internally, so the first write of a frame happens when its fourth octet completes. Any octet that is written is therefore known to belong to a frame long enough to deliver. One flag may serve as the closing flag of one frame and the opening flag of the next.

For B channels a transparent mode skips all HDLC processing. It packs every strobed bit into octets and writes them straight out. When the slot is marked as a D channel, the transparent request is ignored.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: A flag (0 followed by six 1s and a 0) opens a frame, and the next flag closes it. The payload octets are written in arrival order. `wr_last` is high only on the final payload octet, and the two check-sequence octets are not written.
- R2: When one flag sits between two frames, both frames are delivered completely, each with its own `wr_last`.
- R3: A 0 received right after five consecutive 1s is discarded and is not part of the data.
- R4: The check sequence is CRC-16 with reflected polynomial 0x8408 and preset 0xFFFF, run over all data and check bits. A frame whose remainder is not 0xF0B8 has `wr_stat[0]` set on its last write. A good frame has `wr_stat` equal to 0, and writes other than the last always carry status 0.
- R5: When `cfg_addr_en` is 1, a frame whose first octet is neither `cfg_addr` nor 0xFF produces no write. A matching octet or 0xFF lets the frame through.
- R6: Seven consecutive 1s abort the current frame. If writes have already begun, the held oldest octet is written with `wr_last` = 1 and `wr_stat[2]` = 1. Nothing further is written until a new flag arrives.
- R7: A frame with fewer than four complete octets between its flags, check octets included, produces no write. A frame of exactly four octets produces two.
- R8: A frame whose bit count between flags, after zero removal, is not a multiple of eight has `wr_stat[1]` set on its last write.
- R9: With `cfg_transparent` = 1 and `cfg_d_chan` = 0, every eight strobed bits form one octet, first bit in bit 0. That octet is written with `wr_last` = 0 and `wr_stat` = 0, and flag and one-runs have no effect.
- R10: With `cfg_d_chan` = 1, `cfg_transparent` has no effect and frames are deframed as in R1.
- R11: While `rst_n` is low and after its release, `wr_en` stays low until data arrives.
- R12: Only cycles with `bit_en` = 1 move the stream. The value of `bit_in` in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Marks a cycle carrying a line bit |
| bit_in | input | 1 | Serial line bit |
| cfg_d_chan | input | 1 | Slot is a D channel (blocks transparent mode) |
| cfg_transparent | input | 1 | Request raw octet packing |
| cfg_addr_en | input | 1 | Enable first-octet address filtering |
| cfg_addr | input | 8 | Accepted station address |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | Octet to write |
| wr_last | output | 1 | Octet ends a frame |
| wr_stat | output | 3 | End status: bit0 check error, bit1 misaligned, bit2 aborted |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- A stuffed zero never enters the data path.
- Flag, abort and data events are mutually exclusive.
- Writes only follow a strobed bit.
- A nonzero status appears only on an end write.
- A dropped frame writes nothing.
- Transparent octets never carry an end marker.

The bench scenarios are the only evidence for octet content and order, for correct remainder and alignment flags, and for both frames arriving around a shared flag. They also show the length threshold, address acceptance by exact match and broadcast, and recovery after an abort. The same applies to the D-channel override of transparent mode.

// File: rtl/hdlc_rx_pkg.sv
// Shared constants for the HDLC receive deframer.
// Assumes octets are 8 bits and the check sequence is CRC-16 with reflected bit order.
package hdlc_rx_pkg;
    localparam logic [15:0] CRC_POLY = 16'h8408;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD = 16'hF0B8;
    localparam int ST_W     = 3;
    localparam int ST_CRC   = 0;
    localparam int ST_ALIGN = 1;
    localparam int ST_ABORT = 2;
    localparam logic [7:0] ADDR_BCAST = 8'hFF;
endpackage

// File: rtl/hdlc_rx_bitproc.sv
// Line bit processor: counts runs of ones and recognises flags, aborts and
// stuffed zeros. Surviving bits pass through a delay of FLAG_LEN-1 bits, so
// the leading bits of a flag are dropped before they reach the octet stage.
// Assumes at most one line bit per cycle, marked by bit_en.
module hdlc_rx_bitproc #(
    parameter int FLAG_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic commit,
    output logic cbit,
    output logic flag_evt,
    output logic abort_evt
);
    localparam int DLY       = FLAG_LEN - 1;
    localparam int OW        = $clog2(FLAG_LEN);
    localparam int STUFF_RUN = FLAG_LEN - 3;
    localparam int FLAG_RUN  = FLAG_LEN - 2;

    logic [OW-1:0]  ones;
    logic [DLY-1:0] dly;
    logic [OW-1:0]  dly_cnt;
    logic           stuffed, idle_one, accept;

    // Classify the current line bit from the run of ones before it
    always_comb begin
        stuffed   = bit_en && !bit_in && (ones == OW'(STUFF_RUN));
        flag_evt  = bit_en && !bit_in && (ones == OW'(FLAG_RUN));
        abort_evt = bit_en &&  bit_in && (ones == OW'(FLAG_RUN));
        idle_one  = bit_en &&  bit_in && (ones == OW'(DLY));
        accept    = bit_en && !stuffed && !flag_evt && !abort_evt && !idle_one;
        commit    = accept && (dly_cnt == OW'(DLY));
        cbit      = dly[DLY-1];
    end

    // Track the run of ones, saturating at the abort length
    always_ff @(posedge clk) begin
        if (!rst_n)
            ones <= '0;
        else if (bit_en)
            ones <= !bit_in ? '0 : (ones == OW'(DLY)) ? ones : ones + 1'b1;
    end

    // Delay accepted bits and flush the delay at flags and aborts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly     <= '0;
            dly_cnt <= '0;
        end else if (flag_evt || abort_evt || idle_one) begin
            dly_cnt <= '0;
        end else if (accept) begin
            dly     <= {dly[DLY-2:0], bit_in};
            dly_cnt <= (dly_cnt == OW'(DLY)) ? dly_cnt : dly_cnt + 1'b1;
        end
    end

    // R3: a zero after five ones never reaches the data path
    p_stuff_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_in && ones == OW'(STUFF_RUN)) |-> (!commit && !flag_evt));

    // R1: data, flag and abort events never coincide
    p_event_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, flag_evt, abort_evt}));
endmodule

// File: rtl/hdlc_rx_crc16.sv
// Bit-serial CRC-16 with reflected bit order: preset on init, one step per enabled bit.
// Assumes init and en are never both required in the same cycle (init wins).
module hdlc_rx_crc16
    import hdlc_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc
);
    logic fb;

    // Feedback of the next bit against the low end of the register
    always_comb fb = crc[0] ^ din;

    // Preset or advance the remainder
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            crc <= CRC_INIT;
        else if (en)
            crc <= (crc >> 1) ^ (fb ? CRC_POLY : 16'h0000);
    end
endmodule

// File: rtl/hdlc_rx_framer.sv
// Octet stage: builds octets from committed bits, filters on the first
// octet, holds the newest HOLD_DEPTH octets so the check octets never reach
// the FIFO, and writes end status at the closing flag or an abort. In
// transparent mode it packs raw strobed bits instead.
// Assumes flag_evt, abort_evt and commit are mutually exclusive.
module hdlc_rx_framer
    import hdlc_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MIN_OCTETS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trans,
    input  logic              raw_valid,
    input  logic              raw_bit,
    input  logic              commit,
    input  logic              cbit,
    input  logic              flag_evt,
    input  logic              abort_evt,
    input  logic              addr_en,
    input  logic [DATA_W-1:0] addr,
    input  logic [15:0]       crc_val,
    output logic              crc_init,
    output logic              crc_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic [ST_W-1:0]   wr_stat
);
    localparam int HOLD_DEPTH = MIN_OCTETS - 1;
    localparam int BW         = $clog2(DATA_W);
    localparam int CW         = $clog2(MIN_OCTETS + 1);

    logic              in_frame, drop, trans_q;
    logic [BW-1:0]     bit_cnt;
    logic [CW-1:0]     octet_cnt;
    logic [DATA_W-1:0] shreg, nx_sh;
    logic [DATA_W-1:0] hold [HOLD_DEPTH];
    logic              take, octet_done, flushable;

    // Next shift value and event qualifiers
    always_comb begin
        nx_sh      = {(trans ? raw_bit : cbit), shreg[DATA_W-1:1]};
        take       = commit && in_frame && !drop && !trans;
        octet_done = bit_cnt == BW'(DATA_W - 1);
        flushable  = in_frame && !drop && (octet_cnt == CW'(MIN_OCTETS));
        crc_init   = flag_evt && !trans;
        crc_en     = take;
    end

    // Frame state, octet assembly, hold line and FIFO writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame  <= 1'b0;
            drop      <= 1'b0;
            trans_q   <= 1'b0;
            bit_cnt   <= '0;
            octet_cnt <= '0;
            shreg     <= '0;
            for (int i = 0; i < HOLD_DEPTH; i++) hold[i] <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            wr_last   <= 1'b0;
            wr_stat   <= '0;
        end else begin
            wr_en   <= 1'b0;
            wr_last <= 1'b0;
            wr_stat <= '0;
            trans_q <= trans;
            if (trans) begin
                in_frame <= 1'b0;
                if (!trans_q) begin
                    bit_cnt <= '0;
                end else if (raw_valid) begin
                    shreg   <= nx_sh;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (octet_done) begin
                        wr_en   <= 1'b1;
                        wr_data <= nx_sh;
                    end
                end
            end else if (flag_evt) begin
                if (flushable) begin
                    wr_en             <= 1'b1;
                    wr_data           <= hold[HOLD_DEPTH-1];
                    wr_last           <= 1'b1;
                    wr_stat[ST_CRC]   <= crc_val != CRC_GOOD;
                    wr_stat[ST_ALIGN] <= bit_cnt != '0;
                end
                in_frame  <= 1'b1;
                drop      <= 1'b0;
                bit_cnt   <= '0;
                octet_cnt <= '0;
            end else if (abort_evt) begin
                if (flushable) begin
                    wr_en             <= 1'b1;
                    wr_data           <= hold[HOLD_DEPTH-1];
                    wr_last           <= 1'b1;
                    wr_stat[ST_ABORT] <= 1'b1;
                end
                in_frame <= 1'b0;
            end else if (take) begin
                shreg   <= nx_sh;
                bit_cnt <= bit_cnt + 1'b1;
                if (octet_done) begin
                    hold[0] <= nx_sh;
                    for (int i = 1; i < HOLD_DEPTH; i++) hold[i] <= hold[i-1];
                    if (octet_cnt != CW'(MIN_OCTETS)) octet_cnt <= octet_cnt + 1'b1;
                    if (octet_cnt >= CW'(HOLD_DEPTH)) begin
                        wr_en   <= 1'b1;
                        wr_data <= hold[HOLD_DEPTH-1];
                    end
                    if (octet_cnt == '0 && addr_en && nx_sh != addr && nx_sh != ADDR_BCAST)
                        drop <= 1'b1;
                end
            end
        end
    end

    // R4: status is only ever reported on a frame's final write
    p_stat_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_last) |-> (wr_stat == '0));

    // R9: transparent octets never end a frame
    p_trans_no_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |-> !$past(trans));

    // R12: every write is caused by a strobed bit in the previous cycle
    p_write_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(raw_valid));

    // R5: a frame rejected by the address filter writes nothing
    p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> !wr_en);
endmodule

// File: rtl/hdlc_rx_deframer.sv
// HDLC receive deframer for one channel slot. It chains the line bit
// processor, the CRC and the octet stage. Transparent packing is enabled only
// for B channels. Assumes the configuration inputs are static while a frame
// is in progress.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FLAG_LEN   = 8,
    parameter int MIN_OCTETS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              cfg_d_chan,
    input  logic              cfg_transparent,
    input  logic              cfg_addr_en,
    input  logic [DATA_W-1:0] cfg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic [ST_W-1:0]   wr_stat
);
    logic        trans_act;
    logic        commit, cbit, flag_evt, abort_evt;
    logic        crc_init, crc_en;
    logic [15:0] crc_val;

    // Transparent packing is refused on the D channel
    always_comb trans_act = cfg_transparent && !cfg_d_chan;

    hdlc_rx_bitproc #(.FLAG_LEN(FLAG_LEN)) u_bitproc (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .commit    (commit),
        .cbit      (cbit),
        .flag_evt  (flag_evt),
        .abort_evt (abort_evt)
    );

    hdlc_rx_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .din   (cbit),
        .crc   (crc_val)
    );

    hdlc_rx_framer #(.DATA_W(DATA_W), .MIN_OCTETS(MIN_OCTETS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .trans     (trans_act),
        .raw_valid (bit_en),
        .raw_bit   (bit_in),
        .commit    (commit),
        .cbit      (cbit),
        .flag_evt  (flag_evt),
        .abort_evt (abort_evt),
        .addr_en   (cfg_addr_en),
        .addr      (cfg_addr),
        .crc_val   (crc_val),
        .crc_init  (crc_init),
        .crc_en    (crc_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .wr_stat   (wr_stat)
    );

    // R10: on a D channel no write is ever a transparent one
    p_dchan_no_trans_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_d_chan |-> !trans_act);
endmodule

// File: tb/hdlc_rx_deframer_tb.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       cfg_d_chan = 1'b0;
    logic       cfg_transparent = 1'b0;
    logic       cfg_addr_en = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       wr_last;
    logic [2:0] wr_stat;

    int tests = 0;
    int fails = 0;
    int gap = 0;
    int tx_ones = 0;
    int cap_n = 0;
    logic [7:0] cap_data [64];
    logic       cap_last [64];
    logic [2:0] cap_stat [64];
    logic [7:0] fr [16];

    always #5 clk = ~clk;

    hdlc_rx_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .cfg_d_chan(cfg_d_chan), .cfg_transparent(cfg_transparent),
        .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .wr_stat(wr_stat)
    );

    // Record every FIFO write, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && wr_en && cap_n < 64) begin
            cap_data[cap_n] = wr_data;
            cap_last[cap_n] = wr_last;
            cap_stat[cap_n] = wr_stat;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic send_raw(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = ~b;
        end
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_stuffed(input logic b);
        send_raw(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_raw(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_flag();
        send_raw(1'b0);
        for (int i = 0; i < 6; i++) send_raw(1'b1);
        send_raw(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_stuffed(v[i]);
    endtask

    // mode 0: no check octets, 1: good check octets, 2: corrupted check octets
    task automatic send_frame(input int off, input int n, input int mode);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        for (int i = 0; i < n; i++) begin
            send_byte(fr[off+i]);
            c = crc_byte(c, fr[off+i]);
        end
        fcs = ~c;
        if (mode == 2) fcs[0] = ~fcs[0];
        if (mode != 0) begin
            send_byte(fcs[7:0]);
            send_byte(fcs[15:8]);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_seg(input string req, input int coff, input int base, input int n,
                              input logic [2:0] st, input logic [2:0] mask);
        for (int i = 0; i < n; i++) begin
            chk(cap_data[coff+i] == fr[base+i], req, cap_data[coff+i], fr[base+i]);
            chk(cap_last[coff+i] == (i == n-1), req, cap_last[coff+i], (i == n-1));
            if (i == n-1)
                chk((cap_stat[coff+i] & mask) == st, req, cap_stat[coff+i] & mask, st);
            else
                chk(cap_stat[coff+i] == 3'b000, req, cap_stat[coff+i], 0);
        end
    endtask

    task automatic t_reset();
        // R11: no write during and right after reset
        chk(wr_en == 1'b0, "R11 reset", wr_en, 0);
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0 && cap_n == 0, "R11 idle after reset", cap_n, 0);
    endtask

    task automatic t_basic();
        // R1 R4: four payload octets, good check, check octets not written
        fr[0] = 8'h21; fr[1] = 8'h03; fr[2] = 8'hA5; fr[3] = 8'h5A;
        cap_n = 0;
        send_flag(); send_frame(0, 4, 1); send_flag(); settle();
        chk(cap_n == 4, "R1 octet count", cap_n, 4);
        expect_seg("R1/R4 good frame", 0, 0, 4, 3'b000, 3'b111);
    endtask

    task automatic t_stuff();
        // R3: octets full of ones force inserted zeros on the line
        fr[0] = 8'hFF; fr[1] = 8'h7E; fr[2] = 8'h3F; fr[3] = 8'hF8; fr[4] = 8'hFC;
        cap_n = 0;
        send_flag(); send_frame(0, 5, 1); send_flag(); settle();
        chk(cap_n == 5, "R3 octet count", cap_n, 5);
        expect_seg("R3 zero removal", 0, 0, 5, 3'b000, 3'b111);
    endtask

    task automatic t_shared();
        // R2: one flag closes frame A and opens frame B
        fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33; fr[3] = 8'h44; fr[4] = 8'h55;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); send_frame(3, 2, 1); send_flag(); settle();
        chk(cap_n == 5, "R2 total octets", cap_n, 5);
        expect_seg("R2 first frame", 0, 0, 3, 3'b000, 3'b111);
        expect_seg("R2 second frame", 3, 3, 2, 3'b000, 3'b111);
    endtask

    task automatic t_crc();
        // R4: corrupted check octets flag bit 0 on the last write
        fr[0] = 8'h40; fr[1] = 8'h01; fr[2] = 8'h99;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 2); send_flag(); settle();
        chk(cap_n == 3, "R4 octet count", cap_n, 3);
        expect_seg("R4 check error", 0, 0, 3, 3'b001, 3'b111);
    endtask

    task automatic t_addr();
        // R5: filter passes exact match and 0xFF, drops others
        cfg_addr_en = 1'b1; cfg_addr = 8'h21;
        fr[0] = 8'h30; fr[1] = 8'h01; fr[2] = 8'h02;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); settle();
        chk(cap_n == 0, "R5 mismatch dropped", cap_n, 0);
        fr[0] = 8'hFF;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); settle();
        chk(cap_n == 3, "R5 broadcast accepted", cap_n, 3);
        fr[0] = 8'h21;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); settle();
        chk(cap_n == 3, "R5 match accepted", cap_n, 3);
        expect_seg("R5 match content", 0, 0, 3, 3'b000, 3'b111);
        cfg_addr_en = 1'b0;
    endtask

    task automatic t_short();
        // R7: three octets in total produce nothing, four produce two writes
        fr[0] = 8'h12; fr[1] = 8'h34;
        cap_n = 0;
        send_flag(); send_frame(0, 1, 1); send_flag(); settle();
        chk(cap_n == 0, "R7 short frame dropped", cap_n, 0);
        cap_n = 0;
        send_flag(); send_frame(0, 2, 1); send_flag(); settle();
        chk(cap_n == 2, "R7 minimum frame kept", cap_n, 2);
        expect_seg("R7 minimum content", 0, 0, 2, 3'b000, 3'b111);
    endtask

    task automatic t_align();
        // R8: three extra bits before the closing flag
        fr[0] = 8'h0F; fr[1] = 8'hF0; fr[2] = 8'h66; fr[3] = 8'h99;
        cap_n = 0;
        send_flag(); send_frame(0, 4, 1);
        for (int i = 0; i < 3; i++) send_stuffed(1'b0);
        send_flag(); settle();
        chk(cap_n == 4, "R8 octet count", cap_n, 4);
        expect_seg("R8 misaligned", 0, 0, 4, 3'b010, 3'b010);
    endtask

    task automatic t_abort();
        // R6: abort after writes began, then recovery on the next flag
        fr[0] = 8'hA1; fr[1] = 8'hB2; fr[2] = 8'hC3; fr[3] = 8'hD4; fr[4] = 8'hE5; fr[5] = 8'h11;
        cap_n = 0;
        send_flag(); send_frame(0, 6, 0);
        for (int i = 0; i < 10; i++) send_raw(1'b1);
        settle();
        chk(cap_n == 3, "R6 abort write count", cap_n, 3);
        expect_seg("R6 aborted frame", 0, 0, 3, 3'b100, 3'b100);
        fr[0] = 8'h5C; fr[1] = 8'hC5;
        cap_n = 0;
        send_flag(); send_frame(0, 2, 1); send_flag(); settle();
        chk(cap_n == 2, "R6 recovery count", cap_n, 2);
        expect_seg("R6 recovery content", 0, 0, 2, 3'b000, 3'b111);
    endtask

    task automatic t_trans();
        // R9 R12: raw packing with idle gaps carrying inverted junk bits
        logic [7:0] v [3];
        v[0] = 8'h7E; v[1] = 8'hFF; v[2] = 8'h00;
        cfg_transparent = 1'b1; cfg_d_chan = 1'b0;
        settle();
        gap = 2;
        cap_n = 0;
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < 8; i++) send_raw(v[k][i]);
        settle();
        gap = 0;
        chk(cap_n == 3, "R9 transparent count", cap_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(cap_data[k] == v[k], "R9/R12 transparent data", cap_data[k], v[k]);
            chk(cap_last[k] == 1'b0 && cap_stat[k] == 3'b000, "R9 transparent status",
                {cap_last[k], cap_stat[k]}, 0);
        end
        cfg_transparent = 1'b0;
        settle();
    endtask

    task automatic t_dchan();
        // R10: transparent request ignored on a D channel
        cfg_d_chan = 1'b1; cfg_transparent = 1'b1;
        settle();
        fr[0] = 8'h02; fr[1] = 8'h7F; fr[2] = 8'h80;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); settle();
        chk(cap_n == 3, "R10 D channel deframed", cap_n, 3);
        expect_seg("R10 D channel content", 0, 0, 3, 3'b000, 3'b111);
        cfg_d_chan = 1'b0; cfg_transparent = 1'b0;
    endtask

    task automatic t_gapped();
        // R12: HDLC frame with gaps and junk between strobes
        fr[0] = 8'h3C; fr[1] = 8'hC3; fr[2] = 8'hFF;
        gap = 3;
        cap_n = 0;
        send_flag(); send_frame(0, 3, 1); send_flag(); settle();
        gap = 0;
        chk(cap_n == 3, "R12 gapped count", cap_n, 3);
        expect_seg("R12 gapped content", 0, 0, 3, 3'b000, 3'b111);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(wr_en == 1'b0, "R11 after release", wr_en, 0);
        t_basic();
        t_stuff();
        t_shared();
        t_crc();
        t_addr();
        t_short();
        t_align();
        t_abort();
        t_trans();
        t_dchan();
        t_gapped();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule